// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block recovers characters from an idle-high asynchronous serial line. It oversamples the line at 16 samples per bit, where each sample is paced by a programmable clock divisor. It confirms a falling edge as a start bit only at the middle of the bit, then samples each later bit at its centre. The frame has a start bit, 7 or 8 data bits sent least significant bit first, an optional parity bit, and one or two stop bits.

When a frame completes, the character goes into a host-visible data register and a data-full flag is raised. Three error flags record the outcome of the frame: parity mismatch, a low first stop bit, and a character that arrived while the previous one was still unread. Each error flag stays set until the host pulses its own clear input. While any of the three is set, the receiver refuses new frames.

The synchronized line level is exposed to the host. Software can therefore tell a held-low break from an ordinary framing error. After every frame, the receiver waits for the line to go high before it looks for the next start bit.

Top module: `asrx_top`

## Requirements
- R1: A low level on `rxd_in` starts a frame only if it is still low eight sample ticks after first being seen. A low pulse shorter than half a bit leaves every output unchanged.
- R2: Data bits are assembled least significant bit first. With `cfg_short`=1, seven bits are received and `rdata[7]` reads 0. With `cfg_short`=0, eight bits are received.
- R3: With `cfg_par_en`=1, the bit after the data is a parity bit. The count of ones in the data plus the parity bit must be even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1. Otherwise `err_par` is set. `err_par` never rises except at the end of a frame.
- R4: `err_frm` is set when the first stop bit is sampled low. With `cfg_two_stop`=1, a low second stop bit sets no flag.
- R5: A completed frame finds `rx_full`=0, loads `rdata` and sets `rx_full`, even when the same frame sets `err_par` or `err_frm`. A one-cycle `rd_strobe` pulse clears `rx_full`.
- R6: A frame that completes while `rx_full`=1 sets `err_ovr` and leaves `rdata` unchanged.
- R7: Each error flag stays set until its own clear input (`clr_ovr`, `clr_par`, `clr_frm`) is pulsed. Clearing one flag does not affect the others.
- R8: While any error flag is set, no frame is received, so no flag, data or `rx_full` change results. Reception resumes once all three are clear.
- R9: `rxd_level` follows `rxd_in` two clock cycles later and reads 0 during a break.
- R10: After a frame, the receiver does not look for a new start bit until the line has been seen high. A line held low after a framing error yields no further frame even after the flags are cleared.
- R11: After reset, `rdata`=0, `rx_full`=0, all error flags are 0 and `rxd_level`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_in | input | 1 | Serial line, idle high |
| div_val | input | DIV_W | A sample tick every div_val+1 clocks |
| cfg_short | input | 1 | 1: seven data bits, 0: eight |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | Two stop bits per frame |
| rd_strobe | input | 1 | Host read of the data register |
| clr_ovr | input | 1 | Clear overrun flag |
| clr_par | input | 1 | Clear parity flag |
| clr_frm | input | 1 | Clear framing flag |
| rdata | output | DATA_W | Received character |
| rx_full | output | 1 | Data register holds unread data |
| err_ovr | output | 1 | Sticky overrun flag |
| err_par | output | 1 | Sticky parity flag |
| err_frm | output | 1 | Sticky framing flag |
| rxd_level | output | 1 | Synchronized line level |

## Verification
The assertions assume that the host never pulses a flag clear or `rd_strobe` in the same cycle that a frame completes. They also assume that the format inputs and `div_val` hold steady for a whole frame, and that `rxd_in` is high through reset. The stimulus changes configuration only while the line is idle. It issues reads and clears only in idle gaps or during a long break, well away from the stop-bit sample. Every bit lasts exactly sixteen sample ticks with `div_val`=0, so the receiver never sees a frame that is off rate.

// File: rtl/asrx_pkg.sv
package asrx_pkg;
  typedef enum logic [2:0] {
    S_HUNT,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP1,
    S_STOP2,
    S_WAITHI
  } rx_state_t;
endpackage

// File: rtl/asrx_baud.sv
module asrx_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == div_val);
      if (cnt == div_val) cnt <= '0;
      else                cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/asrx_sync.sv
module asrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/asrx_frame.sv
module asrx_frame
  import asrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic              blocked,
  input  logic              cfg_short,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output logic              done_perr,
  output logic              done_ferr
);
  localparam int SW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W);
  localparam logic [SW-1:0] LAST_S = SW'(OVS - 1);
  localparam logic [SW-1:0] MID_S  = SW'(OVS / 2 - 1);
  localparam logic [BW-1:0] IDX_L  = BW'(DATA_W - 1);
  localparam logic [BW-1:0] IDX_S  = BW'(DATA_W - 2);

  rx_state_t         state;
  logic [SW-1:0]     scnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic [DATA_W-1:0] frame_data;
  logic [BW-1:0]     last_idx;
  logic              at_end;
  logic [SW-1:0]     scnt_nx;

  assign frame_data = cfg_short ? {1'b0, shreg[DATA_W-1:1]} : shreg;
  assign last_idx   = cfg_short ? IDX_S : IDX_L;
  assign at_end     = (scnt == LAST_S);
  assign scnt_nx    = at_end ? '0 : scnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_HUNT;
      scnt      <= '0;
      bitn      <= '0;
      shreg     <= '0;
      pbit      <= 1'b0;
      done      <= 1'b0;
      done_data <= '0;
      done_perr <= 1'b0;
      done_ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_HUNT: begin
          if (tick && !blocked && !rxd_s) begin
            state <= S_START;
            scnt  <= '0;
          end
        end
        S_START: begin
          if (tick) begin
            if (scnt == MID_S) begin
              scnt  <= '0;
              bitn  <= '0;
              state <= rxd_s ? S_HUNT : S_DATA;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (tick) begin
            scnt <= scnt_nx;
            if (at_end) begin
              shreg <= {rxd_s, shreg[DATA_W-1:1]};
              if (bitn == last_idx) state <= cfg_par_en ? S_PAR : S_STOP1;
              else                  bitn  <= bitn + 1'b1;
            end
          end
        end
        S_PAR: begin
          if (tick) begin
            scnt <= scnt_nx;
            if (at_end) begin
              pbit  <= rxd_s;
              state <= S_STOP1;
            end
          end
        end
        S_STOP1: begin
          if (tick) begin
            scnt <= scnt_nx;
            if (at_end) begin
              done      <= 1'b1;
              done_data <= frame_data;
              done_perr <= cfg_par_en & ((^frame_data) ^ pbit ^ cfg_par_odd);
              done_ferr <= ~rxd_s;
              state     <= cfg_two_stop ? S_STOP2 : S_WAITHI;
            end
          end
        end
        S_STOP2: begin
          if (tick) begin
            scnt <= scnt_nx;
            if (at_end) state <= S_WAITHI;
          end
        end
        S_WAITHI: begin
          if (rxd_s) state <= S_HUNT;
        end
        default: state <= S_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/asrx_status.sv
module asrx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] done_data,
  input  logic              done_perr,
  input  logic              done_ferr,
  input  logic              rd_strobe,
  input  logic              clr_ovr,
  input  logic              clr_par,
  input  logic              clr_frm,
  output logic [DATA_W-1:0] rdata,
  output logic              rx_full,
  output logic              err_ovr,
  output logic              err_par,
  output logic              err_frm,
  output logic              blocked
);
  logic load;
  assign load    = done & ~rx_full;
  assign blocked = err_ovr | err_par | err_frm;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      rx_full <= 1'b0;
      err_ovr <= 1'b0;
      err_par <= 1'b0;
      err_frm <= 1'b0;
    end else begin
      if (load) rdata <= done_data;

      if (load)           rx_full <= 1'b1;
      else if (rd_strobe) rx_full <= 1'b0;

      if (done && rx_full) err_ovr <= 1'b1;
      else if (clr_ovr)    err_ovr <= 1'b0;

      if (done && done_perr) err_par <= 1'b1;
      else if (clr_par)      err_par <= 1'b0;

      if (done && done_ferr) err_frm <= 1'b1;
      else if (clr_frm)      err_frm <= 1'b0;
    end
  end
endmodule

// File: rtl/asrx_top.sv
module asrx_top #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DIV_W  = 12,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_in,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              cfg_short,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              rd_strobe,
  input  logic              clr_ovr,
  input  logic              clr_par,
  input  logic              clr_frm,
  output logic [DATA_W-1:0] rdata,
  output logic              rx_full,
  output logic              err_ovr,
  output logic              err_par,
  output logic              err_frm,
  output logic              rxd_level
);
  logic              tick;
  logic              rxd_s;
  logic              blocked;
  logic              fr_done;
  logic [DATA_W-1:0] fr_data;
  logic              fr_perr;
  logic              fr_ferr;

  asrx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .div_val(div_val), .tick(tick)
  );

  asrx_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .d_in(rxd_in), .d_out(rxd_s)
  );

  asrx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk(clk), .rst(rst), .tick(tick), .rxd_s(rxd_s), .blocked(blocked),
    .cfg_short(cfg_short), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .done(fr_done), .done_data(fr_data),
    .done_perr(fr_perr), .done_ferr(fr_ferr)
  );

  asrx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .done(fr_done), .done_data(fr_data),
    .done_perr(fr_perr), .done_ferr(fr_ferr), .rd_strobe(rd_strobe),
    .clr_ovr(clr_ovr), .clr_par(clr_par), .clr_frm(clr_frm),
    .rdata(rdata), .rx_full(rx_full), .err_ovr(err_ovr),
    .err_par(err_par), .err_frm(err_frm), .blocked(blocked)
  );

  assign rxd_level = rxd_s;
endmodule

// File: rtl/asrx_checker.sv
module asrx_checker #(
  parameter int DATA_W = 8,
  parameter int SYNC   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              rxd_in,
  input logic              rxd_level,
  input logic              rd_strobe,
  input logic              clr_ovr,
  input logic              clr_par,
  input logic              clr_frm,
  input logic              done,
  input logic [DATA_W-1:0] rdata,
  input logic              rx_full,
  input logic              err_ovr,
  input logic              err_par,
  input logic              err_frm
);
  AST_NO_SPURIOUS_PAR: assert property (@(posedge clk) disable iff (rst)
    (!done && !err_par) |=> !err_par); // R3
  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    (done && !rx_full) |=> rx_full); // R5
  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !done) |=> !rx_full); // R5
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (done && rx_full) |=> (err_ovr && $stable(rdata))); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_ovr && !clr_ovr) |=> err_ovr); // R7
  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_par && !clr_par) |=> err_par); // R7
  AST_FRM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_frm && !clr_frm) |=> err_frm); // R7
  AST_BLOCKED_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
    (err_ovr || err_par || err_frm) |-> !done); // R8
  AST_LINE_READBACK: assert property (@(posedge clk) disable iff (rst)
    rxd_level == $past(rxd_in, SYNC)); // R9
endmodule

bind asrx_top asrx_checker #(.DATA_W(DATA_W), .SYNC(SYNC)) u_chk (
  .clk(clk), .rst(rst), .rxd_in(rxd_in), .rxd_level(rxd_level),
  .rd_strobe(rd_strobe), .clr_ovr(clr_ovr), .clr_par(clr_par),
  .clr_frm(clr_frm), .done(fr_done), .rdata(rdata), .rx_full(rx_full),
  .err_ovr(err_ovr), .err_par(err_par), .err_frm(err_frm)
);

// File: tb/test_asrx_top.sv
module test_asrx_top;
  localparam int DW = 8;
  localparam int BIT = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, rxd_in = 1'b1;
  logic [11:0] div_val = '0;
  logic cfg_short = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0;
  logic rd_strobe = 0, clr_ovr = 0, clr_par = 0, clr_frm = 0;
  logic [DW-1:0] rdata;
  logic rx_full, err_ovr, err_par, err_frm, rxd_level;

  asrx_top i_asrx_top (
    .clk(clk), .rst(rst), .rxd_in(rxd_in), .div_val(div_val),
    .cfg_short(cfg_short), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .rd_strobe(rd_strobe), .clr_ovr(clr_ovr),
    .clr_par(clr_par), .clr_frm(clr_frm), .rdata(rdata), .rx_full(rx_full),
    .err_ovr(err_ovr), .err_par(err_par), .err_frm(err_frm),
    .rxd_level(rxd_level)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R11";
  bit hold = 1'b1;
  int stab = 0;
  logic prev_rxd = 1'b1;

  logic [DW-1:0] m_data = '0;
  bit m_full = 0, m_ovr = 0, m_par = 0, m_frm = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison with the behavioural model
  always @(posedge clk) begin
    #2;
    if (rxd_in == prev_rxd) stab++; else stab = 0;
    prev_rxd = rxd_in;
    if (!rst && !hold) begin
      n_chk++;
      if (rdata !== m_data || rx_full !== m_full || err_ovr !== m_ovr ||
          err_par !== m_par || err_frm !== m_frm) begin
        n_fail++;
        $display("FAIL %s actual=%h/%b%b%b%b expected=%h/%b%b%b%b", cur_req,
                 rdata, rx_full, err_ovr, err_par, err_frm,
                 m_data, m_full, m_ovr, m_par, m_frm);
      end
    end
    if (!rst && stab >= 2) begin
      n_chk++;
      if (rxd_level !== rxd_in) begin
        n_fail++;
        $display("FAIL R9 actual=%b expected=%b", rxd_level, rxd_in);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(input logic b);
    rxd_in = b;
    cyc(BIT);
  endtask

  task automatic model_frame(input logic [DW-1:0] dm, input logic pb, input logic s1);
    bit perr;
    perr = cfg_par_en && (((^dm) ^ pb ^ cfg_par_odd) == 1'b1);
    if (m_full) m_ovr = 1;
    else begin
      m_data = dm;
      m_full = 1;
    end
    if (perr) m_par = 1;
    if (!s1) m_frm = 1;
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input bit pflip,
                            input logic s1, input logic s2);
    int nb;
    logic [DW-1:0] dm;
    logic pb;
    bit blocked;
    nb = cfg_short ? DW - 1 : DW;
    dm = cfg_short ? {1'b0, d[DW-2:0]} : d;
    pb = (^dm) ^ cfg_par_odd ^ pflip;
    blocked = m_ovr | m_par | m_frm;
    hold = 1;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (cfg_par_en) drive_bit(pb);
    drive_bit(s1);
    if (!blocked) model_frame(dm, pb, s1);
    hold = 0;
    if (cfg_two_stop) drive_bit(s2);
    rxd_in = 1'b1;
    cyc(20);
  endtask

  task automatic host_read();
    rd_strobe = 1;
    m_full = 0;
    cyc(1);
    rd_strobe = 0;
    cyc(2);
  endtask

  task automatic host_clear(input bit o, input bit p, input bit f);
    clr_ovr = o; clr_par = p; clr_frm = f;
    if (o) m_ovr = 0;
    if (p) m_par = 0;
    if (f) m_frm = 0;
    cyc(1);
    clr_ovr = 0; clr_par = 0; clr_frm = 0;
    cyc(2);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cyc(5);
    rst = 0;
    cyc(2);
    // R11: reset state
    chk("R11", rdata, 0);
    chk("R11", rx_full, 0);
    chk("R11", {err_ovr, err_par, err_frm}, 0);
    chk("R11", rxd_level, 1);
    hold = 0;
    cyc(10);

    // R2 / R5: 8N1 frames
    cur_req = "R2";
    send_frame(8'hA5, 0, 1, 1);
    chk("R2", rdata, 8'hA5);
    chk("R5", rx_full, 1);
    cur_req = "R5";
    host_read();
    chk("R5", rx_full, 0);
    cur_req = "R2";
    send_frame(8'h3C, 0, 1, 1);
    chk("R2", rdata, 8'h3C);
    host_read();

    // R3: seven bits with even parity
    cfg_short = 1; cfg_par_en = 1; cfg_par_odd = 0;
    cyc(4);
    cur_req = "R3";
    send_frame(8'h35, 0, 1, 1);
    chk("R3", err_par, 0);
    chk("R2", rdata, 8'h35);
    host_read();
    cur_req = "R2";
    send_frame(8'hB5, 0, 1, 1);
    chk("R2", rdata, 8'h35);
    host_read();

    // R3: odd parity, correct then wrong
    cfg_par_odd = 1;
    cyc(4);
    cur_req = "R3";
    send_frame(8'h5A, 0, 1, 1);
    chk("R3", err_par, 0);
    host_read();
    send_frame(8'h2B, 1, 1, 1);
    chk("R3", err_par, 1);
    chk("R5", rx_full, 1);
    chk("R5", rdata, 8'h2B);

    // R8: frame ignored while blocked
    cur_req = "R8";
    send_frame(8'h11, 0, 1, 1);
    chk("R8", rdata, 8'h2B);
    chk("R8", err_ovr, 0);

    // R7: clearing other flags keeps parity flag
    cur_req = "R7";
    host_clear(1, 0, 1);
    cyc(50);
    chk("R7", err_par, 1);
    host_clear(0, 1, 0);
    chk("R7", err_par, 0);
    host_read();
    cur_req = "R8";
    send_frame(8'h22, 0, 1, 1);
    chk("R8", rdata, 8'h22);
    host_read();

    // R6: overrun
    cfg_short = 0; cfg_par_en = 0; cfg_par_odd = 0;
    cyc(4);
    cur_req = "R6";
    send_frame(8'h77, 0, 1, 1);
    send_frame(8'h88, 0, 1, 1);
    chk("R6", err_ovr, 1);
    chk("R6", rdata, 8'h77);
    host_clear(1, 0, 0);
    host_read();
    send_frame(8'h99, 0, 1, 1);
    chk("R6", rdata, 8'h99);
    host_read();

    // R4: framing error on first stop, second stop ignored
    cur_req = "R4";
    send_frame(8'h44, 0, 0, 1);
    chk("R4", err_frm, 1);
    chk("R5", rdata, 8'h44);
    host_read();
    host_clear(0, 0, 1);
    cfg_two_stop = 1;
    cyc(4);
    send_frame(8'h66, 0, 1, 0);
    chk("R4", err_frm, 0);
    chk("R4", rdata, 8'h66);
    host_read();
    cfg_two_stop = 0;
    cyc(4);

    // R1: glitch rejected
    cur_req = "R1";
    rxd_in = 0;
    cyc(4);
    rxd_in = 1;
    cyc(40);
    chk("R1", rx_full, 0);

    // R9 / R10: break
    cur_req = "R9";
    hold = 1;
    rxd_in = 0;
    cyc(BIT * 12);
    model_frame('0, 1'b0, 1'b0);
    hold = 0;
    cyc(2);
    chk("R9", rxd_level, 0);
    chk("R9", err_frm, 1);
    cur_req = "R10";
    host_read();
    host_clear(1, 1, 1);
    cyc(BIT * 15);
    chk("R10", rx_full, 0);
    chk("R10", err_frm, 0);
    rxd_in = 1;
    cyc(20);
    send_frame(8'h5A, 0, 1, 1);
    chk("R10", rdata, 8'h5A);
    host_read();
    cyc(10);
    finish_run();
  end
endmodule